// File: doc/BRIEF.md
# Radix-4 Survivor Traceback Unit with Rotating Banks

This unit sits behind the add-compare-select stage of a 64-state convolutional decoder that works two trellis stages per step. Each step it takes one 2-bit survivor decision per state, stores the step in one of three equal banks, and traces back through the stored steps to recover the decoded information bits. It returns them in transmission order, two per step. It does not compute path metrics.

The survivor store is split into three banks of `TB_STEPS/3` steps each. While a bank is being filled, the same slot of that bank is read just before it is overwritten. This read is the decode traceback over the data that bank held three epochs earlier. At the same time, the bank filled just before is traced from the supplied best state to find the state where decoding starts. The third bank holds its data until its turn comes. The roles advance every time a bank fills. Each bank alternates its fill direction, so the decode read and the write always hit the same address. A small reversal buffer uses the same trick to turn the time-reversed decode bits back into forward order.

Nothing advances unless the decision strobe is high. Gaps in the input only stretch the timing and never change the result.

Top module: `vit_traceback`

## Requirements
- R1: The state is the last six information bits with bit 0 newest. Field `dec_bits[2s+1:2s]` gives, for state s, the two oldest bits of its predecessor, so the predecessor is {field, s[5:2]}. A step ending in state s decoded the pair s[1:0], with s[1] the earlier bit.
- R2: `best_state` is sampled only on the valid step that completes a bank (step indices k with k mod (TB_STEPS/3) = TB_STEPS/3 - 1). Its value on all other steps has no effect on the output.
- R3: Decoded pairs leave in the order their steps arrived. `out_pair[1]` is the earlier bit and `out_pair[0]` the later one.
- R4: The pair of valid step t appears in the cycle after valid step t + 4*(TB_STEPS/3), which is TB_STEPS + TB_STEPS/3 steps later.
- R5: `out_valid` is high only in the cycle after a cycle with `dec_valid` high. It stays low for the first 4*(TB_STEPS/3) valid steps after reset.
- R6: In the cycle after a cycle with `dec_valid` low, `out_valid` is low and `out_pair` holds its value. Decision and state inputs in idle cycles have no effect on later output.
- R7: Each valid step writes exactly one bank and an idle cycle writes none. The write bank advances 0, 1, 2, 0 each time a bank fills.
- R8: After reset `out_valid` is 0, `out_pair` is 0, and decoding restarts as if the unit were new.
- R9: Decisions of states off the traced path have no effect. With a correct best state and correct decisions along the true path, the output equals the information bits exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_valid | input | 1 | A new step of decisions is present |
| dec_bits | input | 2*2^STATE_BITS | Per-state 2-bit survivor decisions, state s in bits 2s+1:2s |
| best_state | input | STATE_BITS | Starting state for the convergence trace, used at bank end |
| out_valid | output | 1 | A decoded pair is present |
| out_pair | output | 2 | Decoded bits, bit 1 earlier |

## Verification
The bench builds a true trellis path from random information bits. It fills the decisions of every other state with noise and drives noise on `best_state` except at bank ends. Any decoder that reads the wrong field, the wrong bank or a stale slot, or that samples the start state at the wrong step, then produces wrong bits instead of bits that happen to be right. Runs use both continuous strobes and irregular gaps, including a long gap in mid stream with random idle inputs. A design that advanced a counter or wrote a bank while idle would slip the latency or corrupt a later pair. A second reset in mid stream exposes any fill or direction state that survives reset, because the output would then start early or come out reversed.

// File: rtl/tbu_pkg.sv
package tbu_pkg;

    localparam int NUM_BANKS = 3;

    typedef logic [1:0] bank_sel_t;

    function automatic bank_sel_t bank_after(input bank_sel_t b);
        return (b == 2'd2) ? 2'd0 : b + 2'd1;
    endfunction

    function automatic bank_sel_t bank_before(input bank_sel_t b);
        return (b == 2'd0) ? 2'd2 : b - 2'd1;
    endfunction

endpackage

// File: rtl/tbu_bank.sv
module tbu_bank #(
    parameter int WORD_W = 128,
    parameter int DEPTH  = 8,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [WORD_W-1:0] rdata
);
    logic [WORD_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    // read returns the old word even when the same slot is written this cycle
    assign rdata = mem_q[raddr];
endmodule

// File: rtl/tbu_tracer.sv
module tbu_tracer #(
    parameter int STATE_BITS = 6,
    localparam int WORD_W    = 2 * (1 << STATE_BITS)
) (
    input  logic [STATE_BITS-1:0] cur,
    input  logic [WORD_W-1:0]     word,
    output logic [STATE_BITS-1:0] pred
);
    logic [1:0] choice;

    assign choice = word[{cur, 1'b0} +: 2];
    assign pred   = {choice, cur[STATE_BITS-1:2]};
endmodule

// File: rtl/tbu_reorder.sv
module tbu_reorder #(
    parameter int DEPTH = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic [AW-1:0] addr,
    input  logic [1:0]    push_bits,
    output logic [1:0]    pop_bits
);
    logic [1:0] lifo_q [DEPTH];

    always_ff @(posedge clk) begin
        if (en) begin
            lifo_q[addr] <= push_bits;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pop_bits <= '0;
        end else if (en) begin
            pop_bits <= lifo_q[addr];
        end
    end
endmodule

// File: rtl/vit_traceback.sv
module vit_traceback
    import tbu_pkg::*;
#(
    parameter int STATE_BITS = 6,
    parameter int TB_STEPS   = 24
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            dec_valid,
    input  logic [2*(1<<STATE_BITS)-1:0]    dec_bits,
    input  logic [STATE_BITS-1:0]           best_state,
    output logic                            out_valid,
    output logic [1:0]                      out_pair
);
    localparam int NSTATES    = 1 << STATE_BITS;
    localparam int WORD_W     = 2 * NSTATES;
    localparam int BANK_STEPS = TB_STEPS / NUM_BANKS;
    localparam int AW         = (BANK_STEPS > 1) ? $clog2(BANK_STEPS) : 1;
    localparam logic [AW-1:0] LAST_STEP = AW'(BANK_STEPS - 1);
    localparam logic [2:0]    FILL_FULL = 3'd4;

    typedef struct packed {
        logic [AW-1:0]        step;
        bank_sel_t            wbank;
        logic [NUM_BANKS-1:0] wdir;
        logic                 rdir;
        logic [2:0]           fill;
    } ctrl_t;

    ctrl_t                  ctrl_q;
    bank_sel_t              wbank;
    bank_sel_t              cbank;
    logic                   bank_end;
    logic [NUM_BANKS-1:0]   bank_we;
    logic [AW-1:0]          wr_addr;
    logic [AW-1:0]          cv_addr;
    logic [AW-1:0]          ro_addr;
    logic [WORD_W-1:0]      bank_rd [NUM_BANKS];
    logic [WORD_W-1:0]      conv_word;
    logic [WORD_W-1:0]      dec_word;
    logic [STATE_BITS-1:0]  cs_q, ds_q;
    logic [STATE_BITS-1:0]  cs_pred, ds_pred;

    function automatic logic [AW-1:0] slot(input logic dir, input logic [AW-1:0] k);
        return dir ? (LAST_STEP - k) : k;
    endfunction

    assign wbank    = ctrl_q.wbank;
    assign cbank    = bank_before(wbank);
    assign bank_end = dec_valid && (ctrl_q.step == LAST_STEP);
    assign wr_addr  = slot(ctrl_q.wdir[wbank], ctrl_q.step);
    assign cv_addr  = slot(ctrl_q.wdir[cbank], ctrl_q.step);
    assign ro_addr  = slot(ctrl_q.rdir, ctrl_q.step);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic [AW-1:0] raddr_b;
        assign bank_we[b] = dec_valid && (wbank == bank_sel_t'(b));
        assign raddr_b    = (wbank == bank_sel_t'(b)) ? wr_addr : cv_addr;
        tbu_bank #(.WORD_W(WORD_W), .DEPTH(BANK_STEPS)) u_bank (
            .clk   (clk),
            .we    (bank_we[b]),
            .waddr (wr_addr),
            .wdata (dec_bits),
            .raddr (raddr_b),
            .rdata (bank_rd[b])
        );
    end

    always_comb begin
        conv_word = '0;
        dec_word  = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (cbank == bank_sel_t'(b)) conv_word = bank_rd[b];
            if (wbank == bank_sel_t'(b)) dec_word  = bank_rd[b];
        end
    end

    tbu_tracer #(.STATE_BITS(STATE_BITS)) u_conv (
        .cur  (cs_q),
        .word (conv_word),
        .pred (cs_pred)
    );

    tbu_tracer #(.STATE_BITS(STATE_BITS)) u_decode (
        .cur  (ds_q),
        .word (dec_word),
        .pred (ds_pred)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q    <= '0;
            cs_q      <= '0;
            ds_q      <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= dec_valid && (ctrl_q.fill == FILL_FULL);
            if (dec_valid) begin
                if (bank_end) begin
                    ctrl_q.step        <= '0;
                    ctrl_q.wbank       <= bank_after(wbank);
                    ctrl_q.wdir[wbank] <= ~ctrl_q.wdir[wbank];
                    ctrl_q.rdir        <= ~ctrl_q.rdir;
                    if (ctrl_q.fill != FILL_FULL) begin
                        ctrl_q.fill <= ctrl_q.fill + 3'd1;
                    end
                    cs_q <= best_state;
                    ds_q <= cs_pred;
                end else begin
                    ctrl_q.step <= ctrl_q.step + AW'(1);
                    cs_q        <= cs_pred;
                    ds_q        <= ds_pred;
                end
            end
        end
    end

    tbu_reorder #(.DEPTH(BANK_STEPS)) u_reorder (
        .clk       (clk),
        .rst       (rst),
        .en        (dec_valid),
        .addr      (ro_addr),
        .push_bits (ds_q[1:0]),
        .pop_bits  (out_pair)
    );
endmodule

// File: rtl/vit_traceback_chk.sv
module vit_traceback_chk
    import tbu_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       dec_valid,
    input logic       out_valid,
    input logic [1:0] out_pair,
    input logic [2:0] bank_we,
    input bank_sel_t  wbank,
    input logic       bank_end
);
    a_r5_out_needs_input: assert property (@(posedge clk) disable iff (rst)
        !dec_valid |=> !out_valid);

    a_r6_pair_holds_idle: assert property (@(posedge clk) disable iff (rst)
        !dec_valid |=> $stable(out_pair));

    a_r7_one_bank_written: assert property (@(posedge clk) disable iff (rst)
        $countones(bank_we) == (dec_valid ? 1 : 0));

    a_r7_bank_rotates: assert property (@(posedge clk) disable iff (rst)
        bank_end |=> (wbank == bank_after($past(wbank))));

    a_r7_bank_in_range: assert property (@(posedge clk) disable iff (rst)
        wbank != 2'd3);

    a_r7_bank_steady_idle: assert property (@(posedge clk) disable iff (rst)
        !dec_valid |=> $stable(wbank));
endmodule

bind vit_traceback vit_traceback_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .dec_valid (dec_valid),
    .out_valid (out_valid),
    .out_pair  (out_pair),
    .bank_we   (bank_we),
    .wbank     (wbank),
    .bank_end  (bank_end)
);

// File: tb/vit_traceback_tb_top.sv
module vit_traceback_tb_top;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int SB = 6;
    localparam int TB = 24;
    localparam int L  = TB / 3;
    localparam int NS = 1 << SB;
    localparam int LAT = 4 * L;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              dec_valid = 1'b0;
    logic [2*NS-1:0]   dec_bits = '0;
    logic [SB-1:0]     best_state = '0;
    logic              out_valid;
    logic [1:0]        out_pair;

    always #10 clk = ~clk;

    vit_traceback #(.STATE_BITS(SB), .TB_STEPS(TB)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .dec_valid  (dec_valid),
        .dec_bits   (dec_bits),
        .best_state (best_state),
        .out_valid  (out_valid),
        .out_pair   (out_pair)
    );

    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;
    logic [1:0]  exp_pair [0:511];
    logic [SB-1:0] cur_state;
    int          step_idx;
    bit          prev_v;
    int          prev_i;
    logic [1:0]  last_out;

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        dec_valid = 1'b0;
        repeat (3) @(negedge clk);
        check("R8 out_valid after reset", int'(out_valid), 0);
        check("R8 out_pair after reset", int'(out_pair), 0);
        rst = 1'b0;
        prev_v = 1'b0;
        prev_i = 0;
        last_out = 2'b00;
        step_idx = 0;
        cur_state = '0;
    endtask

    // check the result of the previous edge, then drive the next cycle
    task automatic cycle(input bit v);
        logic [1:0]    u;
        logic [SB-1:0] nxt;
        @(negedge clk);
        if (prev_v) begin
            if (prev_i >= LAT) begin
                check("R4 R5 out_valid after fill", int'(out_valid), 1);
                check("R1 R2 R3 R9 decoded pair", int'(out_pair), int'(exp_pair[prev_i - LAT]));
            end else begin
                check("R5 out_valid before fill", int'(out_valid), 0);
            end
        end else begin
            check("R5 R6 out_valid idle", int'(out_valid), 0);
            check("R6 out_pair held idle", int'(out_pair), int'(last_out));
        end
        last_out = out_pair;
        prev_v = v;
        prev_i = step_idx;
        for (int w = 0; w < (2 * NS) / 32; w++) dec_bits[w*32 +: 32] = $urandom;
        best_state = SB'($urandom);
        if (v) begin
            u = 2'($urandom);
            nxt = {cur_state[SB-3:0], u};
            dec_bits[2*nxt +: 2] = cur_state[SB-1:SB-2];
            if ((step_idx % L) == L - 1) best_state = nxt;
            exp_pair[step_idx] = u;
            cur_state = nxt;
            step_idx++;
        end
        dec_valid = v;
    endtask

    initial begin
        do_reset();
        // continuous stream
        for (int i = 0; i < 130; i++) cycle(1'b1);
        for (int i = 0; i < 4; i++) cycle(1'b0);
        // partway stream, then reset in the middle of it
        for (int i = 0; i < 45; i++) cycle(1'b1);
        do_reset();
        // irregular gaps plus one long idle stretch
        begin
            bit long_done = 1'b0;
            while (step_idx < 150) begin
                if (!long_done && step_idx == 60) begin
                    long_done = 1'b1;
                    for (int g = 0; g < 40; g++) cycle(1'b0);
                end
                cycle(($urandom % 3) != 0);
            end
        end
        cycle(1'b0);
        cycle(1'b0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule